// File: doc/BRIEF.md
# Chunk-Tree Fault Prefetcher

This block sits beside a GPU fault queue and turns each page-fault address into a migration decision for one tracked 2 MB region of virtual address space. The region is treated as a small tree. The root is the 2 MB chunk. It has two 1 MB halves as children. Each half has sixteen 64 KB leaves. The block remembers which leaves have already been requested, so the same data is never asked for twice.

A fault in a fresh leaf normally asks for just that 64 KB leaf. Once a configurable number of distinct leaves under the same half have faulted, the fault that reaches that count asks for the whole 1 MB half instead. That half is then marked as fully fetched. This lets the fetch size follow spatial locality, while never going past one half.

The decision is registered, so a request appears one cycle after the fault that causes it. Faults may arrive on back-to-back cycles. Each fault sees the state left by the previous one. The tracked chunk base and all the tree dimensions are parameters.

Top module: `pfp_top`

## Requirements
- R1: After reset, or after a clear, no leaf is marked fetched. With the promotion threshold above one, the first fault in any leaf produces a 64 KB request. No request or out-of-range flag is raised while no fault is presented.
- R2: A fault in an unfetched leaf of an unpromoted half produces a leaf request, provided the half's count of already fetched leaves plus one is below the threshold. The request is `req_valid_o` high for exactly one cycle, on the cycle after the fault. It carries `req_base_o` equal to the fault address with bits [15:0] cleared and `req_size_o` equal to 65536. The leaf is then marked fetched.
- R3: A fault in an unfetched leaf that makes the half's fetched-leaf count reach `PROMOTE_THRESH` (default 2) produces a half request instead. It carries `req_base_o` equal to the fault address with bits [19:0] cleared and `req_size_o` equal to 1048576. The half is then marked promoted, with all sixteen leaves fetched.
- R4: Any fault inside a promoted half produces no request.
- R5: A fault inside a leaf already fetched produces no request.
- R6: Bit 20 of the address selects the half, and bits [19:16] select the leaf. Leaf counts and promotion are kept separately per half. Faults in one half never change the decision taken for the other half.
- R7: A fault whose address bits above bit 20 differ from those of `CHUNK_BASE` raises `oor_o` for one cycle on the next cycle. It produces no request and changes no state.
- R8: `clear_i` is synchronous. It returns every leaf and half to the unfetched state. A fault presented in the same cycle as `clear_i` is dropped: it produces no request and marks nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous wipe of all tree state |
| fault_valid_i | input | 1 | A fault address is presented this cycle |
| fault_addr_i | input | ADDR_W | Faulting virtual byte address |
| req_valid_o | output | 1 | Migration request valid (one cycle) |
| req_base_o | output | ADDR_W | Aligned base of the region to migrate, zero when idle |
| req_size_o | output | ADDR_W | Region size in bytes (65536 or 1048576), zero when idle |
| oor_o | output | 1 | Previous fault lay outside the tracked chunk |

## Verification
The bench builds the block with 40-bit addresses and a chunk base of 0x40600000. It sets the promotion threshold to 3 rather than the default 2. With that threshold, each half passes through a state with one leaf fetched and one with two leaves fetched before promotion. This brings the leaf-request path, the count boundary and the promotion into reach within a few faults.

The bench sweeps leaf orderings over both halves across several clear cycles. The sweeps mix in repeat faults, out-of-range addresses on both sides of the chunk, idle cycles, and a clear that coincides with a fault.

// File: rtl/pfp_pkg.sv
package pfp_pkg;
   typedef enum logic [1:0] {
      GRAN_NONE = 2'd0,
      GRAN_LEAF = 2'd1,
      GRAN_HALF = 2'd2
   } gran_e;
endpackage

// File: rtl/pfp_addr_split.sv
module pfp_addr_split #(
   parameter int ADDR_W      = 40,
   parameter int LEAF_SHIFT  = 16,
   parameter int HALF_SHIFT  = 20,
   parameter int CHUNK_SHIFT = 21,
   parameter logic [ADDR_W-1:0] CHUNK_BASE = '0,
   localparam int HALF_IDX_W = CHUNK_SHIFT - HALF_SHIFT,
   localparam int LEAF_IDX_W = HALF_SHIFT - LEAF_SHIFT
) (
   input  logic [ADDR_W-1:0]     addr_i,
   output logic                  in_range_o,
   output logic [HALF_IDX_W-1:0] half_idx_o,
   output logic [LEAF_IDX_W-1:0] leaf_idx_o
);
   always_comb begin
      in_range_o = (addr_i[ADDR_W-1:CHUNK_SHIFT] == CHUNK_BASE[ADDR_W-1:CHUNK_SHIFT]);
      half_idx_o = addr_i[CHUNK_SHIFT-1:HALF_SHIFT];
      leaf_idx_o = addr_i[HALF_SHIFT-1:LEAF_SHIFT];
   end
endmodule

// File: rtl/pfp_half_node.sv
module pfp_half_node
   import pfp_pkg::*;
#(
   parameter int LEAVES         = 16,
   parameter int PROMOTE_THRESH = 2,
   localparam int LEAF_IDX_W = $clog2(LEAVES),
   localparam int CNT_W      = $clog2(LEAVES + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clear_i,
   input  logic                  sel_i,
   input  logic [LEAF_IDX_W-1:0] leaf_i,
   output gran_e                 gran_o
);
   logic [LEAVES-1:0] fetched_q;
   logic              promoted_q;
   logic [CNT_W-1:0]  cnt;

   always_comb begin
      cnt = '0;
      for (int i = 0; i < LEAVES; i++) begin
         cnt = cnt + CNT_W'(fetched_q[i]);
      end
   end

   always_comb begin
      gran_o = GRAN_NONE;
      if (!promoted_q && !fetched_q[leaf_i]) begin
         if (int'(cnt) + 1 >= PROMOTE_THRESH) gran_o = GRAN_HALF;
         else                                 gran_o = GRAN_LEAF;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fetched_q  <= '0;
         promoted_q <= 1'b0;
      end else if (clear_i) begin
         fetched_q  <= '0;
         promoted_q <= 1'b0;
      end else if (sel_i) begin
         case (gran_o)
            GRAN_HALF: begin
               fetched_q  <= '1;
               promoted_q <= 1'b1;
            end
            GRAN_LEAF: fetched_q[leaf_i] <= 1'b1;
            default: ;
         endcase
      end
   end

   // R3: a promotion leaves the whole half marked fetched
   a_r3_half_fills: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i && !clear_i && gran_o == GRAN_HALF) |=> (promoted_q && (&fetched_q)));
   // R5: a leaf once requested is remembered
   a_r5_leaf_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i && !clear_i && gran_o == GRAN_LEAF) |=> fetched_q[$past(leaf_i)]);
   // R4: promotion is sticky until a clear
   a_r4_promote_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (promoted_q && !clear_i) |=> promoted_q);
   // R8: clear empties the node
   a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (fetched_q == '0 && !promoted_q));
endmodule

// File: rtl/pfp_top.sv
module pfp_top
   import pfp_pkg::*;
#(
   parameter int ADDR_W         = 40,
   parameter int LEAF_SHIFT     = 16,
   parameter int HALF_SHIFT     = 20,
   parameter int CHUNK_SHIFT    = 21,
   parameter int PROMOTE_THRESH = 2,
   parameter logic [ADDR_W-1:0] CHUNK_BASE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              fault_valid_i,
   input  logic [ADDR_W-1:0] fault_addr_i,
   output logic              req_valid_o,
   output logic [ADDR_W-1:0] req_base_o,
   output logic [ADDR_W-1:0] req_size_o,
   output logic              oor_o
);
   localparam int HALF_IDX_W = CHUNK_SHIFT - HALF_SHIFT;
   localparam int LEAF_IDX_W = HALF_SHIFT - LEAF_SHIFT;
   localparam int HALVES     = 1 << HALF_IDX_W;
   localparam int LEAVES     = 1 << LEAF_IDX_W;
   localparam logic [ADDR_W-1:0] ONE        = {{(ADDR_W-1){1'b0}}, 1'b1};
   localparam logic [ADDR_W-1:0] LEAF_BYTES = ONE << LEAF_SHIFT;
   localparam logic [ADDR_W-1:0] HALF_BYTES = ONE << HALF_SHIFT;
   localparam logic [ADDR_W-1:0] CHUNK_MASK = (ONE << CHUNK_SHIFT) - ONE;

   if (!(LEAF_SHIFT > 0 && LEAF_SHIFT < HALF_SHIFT && HALF_SHIFT < CHUNK_SHIFT
         && CHUNK_SHIFT < ADDR_W)) begin : g_bad_shifts
      $error("pfp_top: shifts must satisfy 0 < LEAF < HALF < CHUNK < ADDR_W");
   end
   if (PROMOTE_THRESH < 1 || PROMOTE_THRESH > LEAVES) begin : g_bad_thresh
      $error("pfp_top: PROMOTE_THRESH must lie in 1..leaves per half");
   end
   if ((CHUNK_BASE & CHUNK_MASK) != '0) begin : g_bad_base
      $error("pfp_top: CHUNK_BASE must be aligned to the chunk size");
   end

   logic                  in_range;
   logic [HALF_IDX_W-1:0] half_idx;
   logic [LEAF_IDX_W-1:0] leaf_idx;
   logic                  take;
   gran_e                 gran_w [HALVES];
   gran_e                 gran_sel;

   pfp_addr_split #(
      .ADDR_W(ADDR_W), .LEAF_SHIFT(LEAF_SHIFT), .HALF_SHIFT(HALF_SHIFT),
      .CHUNK_SHIFT(CHUNK_SHIFT), .CHUNK_BASE(CHUNK_BASE)
   ) u_split (
      .addr_i(fault_addr_i), .in_range_o(in_range),
      .half_idx_o(half_idx), .leaf_idx_o(leaf_idx)
   );

   assign take = fault_valid_i && in_range && !clear_i;

   for (genvar h = 0; h < HALVES; h++) begin : g_half
      pfp_half_node #(
         .LEAVES(LEAVES), .PROMOTE_THRESH(PROMOTE_THRESH)
      ) u_node (
         .clk(clk), .rst_n(rst_n), .clear_i(clear_i),
         .sel_i(take && (half_idx == HALF_IDX_W'(h))),
         .leaf_i(leaf_idx), .gran_o(gran_w[h])
      );
   end

   assign gran_sel = gran_w[half_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_valid_o <= 1'b0;
         req_base_o  <= '0;
         req_size_o  <= '0;
         oor_o       <= 1'b0;
      end else begin
         req_valid_o <= 1'b0;
         req_base_o  <= '0;
         req_size_o  <= '0;
         oor_o       <= fault_valid_i && !in_range && !clear_i;
         if (take) begin
            case (gran_sel)
               GRAN_LEAF: begin
                  req_valid_o <= 1'b1;
                  req_base_o  <= fault_addr_i & ~(LEAF_BYTES - ONE);
                  req_size_o  <= LEAF_BYTES;
               end
               GRAN_HALF: begin
                  req_valid_o <= 1'b1;
                  req_base_o  <= fault_addr_i & ~(HALF_BYTES - ONE);
                  req_size_o  <= HALF_BYTES;
               end
               default: ;
            endcase
         end
      end
   end

   // R7: an out-of-range fault never yields a request
   a_r7_oor_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      oor_o |-> !req_valid_o);
   // R8: a fault coinciding with clear is dropped
   a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (!req_valid_o && !oor_o));
   // R1: nothing is emitted without a fault
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_valid_i |=> (!req_valid_o && !oor_o));
   // R2: request sizes are one of the two tree granules
   a_r2_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_o |-> (req_size_o == LEAF_BYTES || req_size_o == HALF_BYTES));
   // R3: request base is aligned to its own size
   a_r3_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_o |-> ((req_base_o & (req_size_o - ONE)) == '0));
endmodule

// File: tb/sim_pfp_top.sv
module sim_pfp_top;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 40;
   localparam int THR = 3;
   localparam logic [AW-1:0] BASE = 40'h00_4060_0000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clear_i = 1'b0;
   logic          fault_valid_i = 1'b0;
   logic [AW-1:0] fault_addr_i = '0;
   logic          req_valid_o;
   logic [AW-1:0] req_base_o;
   logic [AW-1:0] req_size_o;
   logic          oor_o;

   int total = 0;
   int bad = 0;
   bit done = 0;

   logic [15:0] m_fetch [2];
   logic        m_prom  [2];

   always #(CLK_PERIOD/2) clk = ~clk;

   pfp_top #(
      .ADDR_W(AW), .PROMOTE_THRESH(THR), .CHUNK_BASE(BASE)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .clear_i(clear_i),
      .fault_valid_i(fault_valid_i), .fault_addr_i(fault_addr_i),
      .req_valid_o(req_valid_o), .req_base_o(req_base_o),
      .req_size_o(req_size_o), .oor_o(oor_o)
   );

   task automatic chk(input bit ok, input string tag, input logic [AW-1:0] act,
                      input logic [AW-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int h = 0; h < 2; h++) begin
         m_fetch[h] = '0;
         m_prom[h]  = 1'b0;
      end
   endtask

   // Called at a negedge; checks outputs at the following negedge.
   task automatic do_fault(input logic [AW-1:0] addr, input bit clr, input string tag_in);
      logic          ev, eo;
      logic [AW-1:0] eb, es;
      string         tag;
      int            h, l;
      ev = 0; eo = 0; eb = '0; es = '0;
      h = int'(addr[20]);
      l = int'(addr[19:16]);
      if (clr) begin
         tag = "R8";
         model_clear();
      end else if (addr[AW-1:21] != BASE[AW-1:21]) begin
         tag = "R7";
         eo = 1;
      end else if (m_prom[h]) begin
         tag = "R4";
      end else if (m_fetch[h][l]) begin
         tag = "R5";
      end else if ($countones(m_fetch[h]) + 1 >= THR) begin
         tag = "R3";
         ev = 1; eb = addr & ~40'hF_FFFF; es = 40'h10_0000;
         m_fetch[h] = '1; m_prom[h] = 1'b1;
      end else begin
         tag = "R2";
         ev = 1; eb = addr & ~40'hFFFF; es = 40'h1_0000;
         m_fetch[h][l] = 1'b1;
      end
      if (tag_in != "") tag = tag_in;
      clear_i = clr; fault_valid_i = 1'b1; fault_addr_i = addr;
      @(negedge clk);
      clear_i = 1'b0; fault_valid_i = 1'b0;
      chk(req_valid_o == ev, {tag, " valid"}, AW'(req_valid_o), AW'(ev));
      chk(req_base_o == eb, {tag, " base"}, req_base_o, eb);
      chk(req_size_o == es, {tag, " size"}, req_size_o, es);
      chk(oor_o == eo, {tag, " oor"}, AW'(oor_o), AW'(eo));
   endtask

   task automatic idle_check();
      @(negedge clk);
      chk(!req_valid_o && !oor_o, "R1 idle", AW'({req_valid_o, oor_o}), '0);
   endtask

   function automatic logic [AW-1:0] mk(input int h, input int l, input int off);
      return BASE + (AW'(h) << 20) + (AW'(l) << 16) + AW'(off & 16'hFFFF);
   endfunction

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      model_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!req_valid_o && !oor_o && req_size_o == '0, "R1 reset", AW'(req_valid_o), '0);
      idle_check();

      // R1: first fault after reset is a leaf
      do_fault(mk(0, 3, 16'h1234), 0, "R1");
      do_fault(mk(0, 3, 16'h0008), 0, "R5");

      // R6: interleaved halves count separately
      do_fault(mk(0, 0, 0), 1, "R8");
      do_fault(mk(0, 0, 5), 0, "R6");
      do_fault(mk(1, 0, 9), 0, "R6");
      do_fault(mk(0, 1, 7), 0, "R6");
      do_fault(mk(1, 1, 3), 0, "R6");
      do_fault(mk(0, 2, 1), 0, "R6");
      do_fault(mk(1, 15, 16'hFFFF), 0, "R6");
      do_fault(mk(1, 9, 4), 0, "R4");

      // R8: fault coinciding with clear is dropped, then the leaf is fresh
      do_fault(mk(0, 5, 0), 1, "R8");
      do_fault(mk(0, 6, 2), 1, "R8");
      do_fault(mk(0, 6, 2), 0, "R8");
      idle_check();

      // R7: out-of-range on both sides, state unchanged
      do_fault(BASE - 40'h1, 0, "R7");
      do_fault(BASE + 40'h20_0000, 0, "R7");
      do_fault(mk(0, 6, 16'h8000), 0, "R5");

      // sweeps over orderings
      for (int p = 0; p < 6; p++) begin
         do_fault(mk(p & 1, p, 0), 1, "");
         for (int i = 0; i < 40; i++) begin
            if (i % 7 == 6) begin
               do_fault((i % 2 == 1) ? (BASE + 40'h20_0000 + AW'(i * 4099))
                                     : (BASE - 40'h10_0000 + AW'(i)), 0, "");
            end else begin
               do_fault(mk(((i >> 1) ^ p) & 1, (i * 5 + p) % 16, i * 1237), 0, "");
            end
            if (i % 9 == 8) idle_check();
         end
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule